// File: doc/BRIEF.md
# SDR Mobile DRAM Controller with Periodic Refresh

This block sits between a host that issues single 16-bit word reads and writes and a four-bank, x16 single-data-rate synchronous DRAM. It converts each host request into a row-open, column-access sequence on the chip-select, row-strobe, column-strobe and write-enable lines. Every access closes its row with auto-precharge, so no row stays open between requests. After reset it runs the power-up sequence by itself. It then programs the mode register with a CAS latency and burst length fixed at build time, and from then on inserts an auto refresh at a fixed cycle interval.

The host side is a valid/ready request channel. A request carries a write flag, a 24-bit word address (bank, row, column), write data and two byte enables. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. Until that edge the host must hold `req_valid` and every request field steady. `req_ready` is low through power-up, while a command sequence is in progress, and whenever a refresh is due, so refresh always wins over waiting host traffic. The read response has no back-pressure: `rsp_valid` pulses for one cycle with `rsp_data`, and responses come back in request order.

The data bus is split into an output, an output enable and an input, so the tristate buffer lives outside the block. The memory samples every pin on the rising edge after the controller changes it.

Top module: `sdram_ctrl_top`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, the command lines carry NOP (CS,RAS,CAS,WE = 0,1,1,1) and `req_ready` is 0. `req_ready` stays 0 until the mode register has been loaded.
- R2: After reset the controller holds NOP for at least `INIT_CYCLES` cycles. It then issues, in order, a precharge with `sd_addr[10]`=1 (all banks), two auto refreshes and one mode-register load. No activate, read or write appears before the mode-register load.
- R3: The mode-register key on `sd_addr`, with `sd_ba`=0, holds the burst code in bits 2:0 (1→000, 2→001, 4→010, 8→011), the burst order in bit 3 (0 sequential), the CAS latency in bits 6:4 and 1 in bit 9 (single-word write). All other bits are 0. With the defaults (CL 3, burst 1) the key is 0x230.
- R4: Commands are encoded on CS,RAS,CAS,WE as follows: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000, NOP 0111.
- R5: `req_addr[23:22]` drives `sd_ba`. `req_addr[21:9]` drives `sd_addr` at activate. `req_addr[8:0]` drives `sd_addr[8:0]` at read or write, with `sd_addr[10]`=1 for auto-precharge.
- R6: A read or write follows its activate by at least `TRCD` cycles. The next command follows a precharge by at least `TRP` cycles, a refresh by at least `TRC` cycles and a mode load by at least `TMRD` cycles.
- R7: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, initialised and no refresh is due.
- R8: Each write request produces exactly one write command. `sd_dq_oe` is high in that cycle only, and `sd_dqm` = ~`req_be`, with bit 0 covering the lower byte `[7:0]`. Masked bytes keep their previous contents.
- R9: If a read command is on the pins after rising edge k, the value on `sd_dq_in` at edge k+1+`CAS_LAT` is returned on `rsp_data`. `rsp_valid` is high for exactly one cycle after that edge.
- R10: Once initialised, consecutive refresh commands are never further apart than `REF_INTERVAL` plus the length of one access sequence, even under back-to-back host requests. The default interval of 1039 cycles at 133 MHz gives 8192 refreshes per 64 ms.
- R11: A read returns the last value written to that word address, with byte enables applied; a word never written reads as 0 in the bench memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address: bank[23:22], row[21:9], column[8:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = lower byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column/key address |
| sd_dqm | output | 2 | Byte masks, bit 0 = lower byte |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Output enable for the data bus |
| sd_dq_in | input | 16 | Data from memory |

## Verification
On every cycle the assertions check the command timing at the pins: activate-to-column spacing, the gap after refresh and precharge, and that no column access or row activate comes before the mode load. They also check that ready stays low until then, that every column access carries the auto-precharge bit, that the read strobe is a single-cycle pulse and that the refresh gap stays bounded. Only the bench scenarios can show that data lands in the right word with the right byte masks and comes back at the programmed latency. The same goes for the exact init order and mode key, and for refresh pacing under a stream of host requests. Those checks rely on a behavioural memory that decodes the pins.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_REF_A, ST_REF_B, ST_MRS, ST_IDLE, ST_RW
  } seq_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [12:0] mode_key(input int cl, input int bl, input bit interleave);
    logic [12:0] k;
    k      = '0;
    k[2:0] = burst_code(bl);
    k[3]   = interleave;
    k[6:4] = 3'(cl);
    k[9]   = 1'b1;
    return k;
  endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int INTERVAL = 1039
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(INTERVAL + 1);
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      pending <= (pending && !ack) || wrap;
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CAS_LAT = 3,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [CAS_LAT-1:0] sr;

  generate
    if (CAS_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= issue;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[CAS_LAT-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sr[CAS_LAT-1];
      if (sr[CAS_LAT-1]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
  import sdr_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DW          = 16,
  parameter int INIT_CYCLES = 26600,
  parameter int CAS_LAT     = 3,
  parameter int BURST_LEN   = 1,
  parameter bit INTERLEAVE  = 1'b0,
  parameter int TRCD        = 3,
  parameter int TRP         = 3,
  parameter int TRC         = 9,
  parameter int TMRD        = 2,
  parameter int TWR         = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_pending,
  output logic                          ref_ack,
  output logic                          init_done,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]                 req_wdata,
  input  logic [DW/8-1:0]               req_be,
  output logic [3:0]                    cmd,
  output logic                          cke,
  output logic [BANK_W-1:0]             ba,
  output logic [ROW_W-1:0]              addr,
  output logic [DW/8-1:0]               dqm,
  output logic [DW-1:0]                 dq_out,
  output logic                          dq_oe,
  output logic                          rd_issue
);
  localparam int T_POST  = max2(TRC - TRCD, max2(BURST_LEN + CAS_LAT, TWR)) + TRP;
  localparam int L_RCD   = max2(TRCD, 2) - 2;
  localparam int L_RP    = max2(TRP, 2) - 2;
  localparam int L_RC    = max2(TRC, 2) - 2;
  localparam int L_MRD   = max2(TMRD, 2) - 2;
  localparam int L_POST  = max2(T_POST, 2) - 2;
  localparam int L_INIT  = max2(INIT_CYCLES, 1) - 1;
  localparam int CW      = $clog2(max2(L_INIT, max2(L_POST, L_RC)) + 2);
  localparam int AP_BIT  = 10;
  localparam logic [ROW_W-1:0] KEY = mode_key(CAS_LAT, BURST_LEN, INTERLEAVE);

  seq_st_e             st, nxt;
  logic [CW-1:0]       cnt;
  logic                op_we;
  logic [COL_W-1:0]    op_col;
  logic [DW-1:0]       op_data;
  logic [DW/8-1:0]     op_be;

  assign req_ready = (st == ST_IDLE) && !ref_pending;
  assign ref_ack   = (st == ST_IDLE) && ref_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      nxt       <= ST_PRE;
      cnt       <= CW'(L_INIT);
      cmd       <= CMD_NOP;
      cke       <= 1'b0;
      ba        <= '0;
      addr      <= '0;
      dqm       <= '1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rd_issue  <= 1'b0;
      init_done <= 1'b0;
      op_we     <= 1'b0;
      op_col    <= '0;
      op_data   <= '0;
      op_be     <= '0;
    end else begin
      cmd      <= CMD_NOP;
      cke      <= 1'b1;
      dq_oe    <= 1'b0;
      rd_issue <= 1'b0;
      dqm      <= '0;
      unique case (st)
        ST_WAIT: begin
          if (cnt == '0) st <= nxt;
          else           cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          cmd          <= CMD_PRE;
          addr         <= '0;
          addr[AP_BIT] <= 1'b1;
          cnt <= CW'(L_RP);  nxt <= ST_REF_A; st <= ST_WAIT;
        end
        ST_REF_A: begin
          cmd <= CMD_REF;
          cnt <= CW'(L_RC);  nxt <= ST_REF_B; st <= ST_WAIT;
        end
        ST_REF_B: begin
          cmd <= CMD_REF;
          cnt <= CW'(L_RC);  nxt <= ST_MRS;   st <= ST_WAIT;
        end
        ST_MRS: begin
          cmd       <= CMD_MRS;
          ba        <= '0;
          addr      <= KEY;
          init_done <= 1'b1;
          cnt <= CW'(L_MRD); nxt <= ST_IDLE;  st <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd <= CMD_REF;
            cnt <= CW'(L_RC); nxt <= ST_IDLE; st <= ST_WAIT;
          end else if (req_valid) begin
            cmd     <= CMD_ACT;
            ba      <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
            addr    <= req_addr[ROW_W+COL_W-1 -: ROW_W];
            op_we   <= req_we;
            op_col  <= req_addr[COL_W-1:0];
            op_data <= req_wdata;
            op_be   <= req_be;
            cnt <= CW'(L_RCD); nxt <= ST_RW; st <= ST_WAIT;
          end
        end
        ST_RW: begin
          addr              <= '0;
          addr[COL_W-1:0]   <= op_col;
          addr[AP_BIT]      <= 1'b1;
          if (op_we) begin
            cmd    <= CMD_WR;
            dq_out <= op_data;
            dq_oe  <= 1'b1;
            dqm    <= ~op_be;
          end else begin
            cmd      <= CMD_RD;
            rd_issue <= 1'b1;
          end
          cnt <= CW'(L_POST); nxt <= ST_IDLE; st <= ST_WAIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_ctrl_top.sv
module sdram_ctrl_top
  import sdr_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int DW           = 16,
  parameter int INIT_CYCLES  = 26600,
  parameter int REF_INTERVAL = 1039,
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 1,
  parameter bit INTERLEAVE   = 1'b0,
  parameter int TRCD         = 3,
  parameter int TRP          = 3,
  parameter int TRC          = 9,
  parameter int TMRD         = 2,
  parameter int TWR          = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]                 req_wdata,
  input  logic [DW/8-1:0]               req_be,
  output logic                          rsp_valid,
  output logic [DW-1:0]                 rsp_data,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DW/8-1:0]               sd_dqm,
  output logic [DW-1:0]                 sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DW-1:0]                 sd_dq_in
);
  logic       ref_pending, ref_ack, init_done, rd_issue;
  logic [3:0] cmd;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  sdr_ref_timer #(.INTERVAL(REF_INTERVAL)) ref_i (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdr_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW),
    .INIT_CYCLES(INIT_CYCLES), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN),
    .INTERLEAVE(INTERLEAVE), .TRCD(TRCD), .TRP(TRP), .TRC(TRC),
    .TMRD(TMRD), .TWR(TWR)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .cmd(cmd), .cke(sd_cke), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .rd_issue(rd_issue)
  );

  sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk #(
  parameter int ROW_W        = 13,
  parameter int REF_INTERVAL = 1039,
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 1,
  parameter int TRCD         = 3,
  parameter int TRP          = 3,
  parameter int TRC          = 9,
  parameter int TMRD         = 2,
  parameter int TWR          = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             req_ready,
  input logic             rsp_valid
);
  localparam int SAT   = 1 << 20;
  localparam int SLACK = TRC + TRCD + TRP + TWR + CAS_LAT + BURST_LEN + 8;

  logic [3:0] c;
  logic is_act, is_rw, is_ref, is_mrs, is_pre, is_any;
  int   since_act, since_ref, since_pre, since_mrs, ref_gap;
  logic mrs_seen, ref_armed;

  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (c == 4'b0011);
  assign is_rw  = (c == 4'b0101) || (c == 4'b0100);
  assign is_ref = (c == 4'b0001);
  assign is_mrs = (c == 4'b0000);
  assign is_pre = (c == 4'b0010);
  assign is_any = !sd_cs_n && (c != 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 0;
      since_ref <= SAT;
      since_pre <= SAT;
      since_mrs <= SAT;
      ref_gap   <= 0;
      mrs_seen  <= 1'b0;
      ref_armed <= 1'b0;
    end else begin
      since_act <= is_act ? 1 : ((since_act < SAT) ? since_act + 1 : SAT);
      since_ref <= is_ref ? 1 : ((since_ref < SAT) ? since_ref + 1 : SAT);
      since_pre <= is_pre ? 1 : ((since_pre < SAT) ? since_pre + 1 : SAT);
      since_mrs <= is_mrs ? 1 : ((since_mrs < SAT) ? since_mrs + 1 : SAT);
      if (is_mrs) mrs_seen <= 1'b1;
      if (is_ref && mrs_seen) begin
        ref_armed <= 1'b1;
        ref_gap   <= 1;
      end else if (ref_armed && ref_gap < SAT) begin
        ref_gap <= ref_gap + 1;
      end
    end
  end

  // R6
  act_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act >= TRCD));
  // R6
  after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_any |-> (since_ref >= TRC));
  // R6
  after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_any |-> (since_pre >= TRP));
  // R6
  after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_any |-> (since_mrs >= TMRD));
  // R2
  no_early_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_rw) |-> mrs_seen);
  // R1
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mrs_seen);
  // R5
  auto_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> sd_addr[10]);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_armed |-> (ref_gap <= REF_INTERVAL + SLACK));
endmodule

bind sdram_ctrl_top sdram_ctrl_chk #(
  .ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL), .CAS_LAT(CAS_LAT),
  .BURST_LEN(BURST_LEN), .TRCD(TRCD), .TRP(TRP), .TRC(TRC),
  .TMRD(TMRD), .TWR(TWR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/sdram_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module sdram_ctrl_top_tb_top;
  localparam int INIT_CYC = 60;
  localparam int REF_INT  = 120;
  localparam int CL       = 3;
  localparam int TRCD_T   = 3;
  localparam int TRC_T    = 9;
  localparam int SLACK    = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = 16'hDEAD;

  always #10 clk = ~clk;

  sdram_ctrl_top #(.INIT_CYCLES(INIT_CYC), .REF_INTERVAL(REF_INT), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory, samples pins on the rising edge
  logic [15:0] mem [int];
  logic [12:0] open_row [4];
  bit          row_open [4];
  int          act_cyc  [4];
  bit          pv [4];
  logic [15:0] pd [4];

  always @(posedge clk) begin
    logic [3:0] c;
    int key;
    logic [15:0] old;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      case (c)
        4'b0011: begin
          chk(!row_open[sd_ba], "R5 activate on open bank", 1, 0);
          row_open[sd_ba] = 1'b1; open_row[sd_ba] = sd_addr; act_cyc[sd_ba] = cyc;
        end
        4'b0100, 4'b0101: begin
          chk(row_open[sd_ba], "R5 column access to closed bank", 0, 1);
          chk(cyc - act_cyc[sd_ba] >= TRCD_T, "R6 activate-to-column", cyc - act_cyc[sd_ba], TRCD_T);
          key = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
          old = mem.exists(key) ? mem[key] : 16'h0000;
          if (c == 4'b0100) begin
            chk(sd_dq_oe, "R8 oe on write", sd_dq_oe, 1);
            mem[key] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                        sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
          end else begin
            pv[CL-1] = 1'b1; pd[CL-1] = old;
          end
          if (sd_addr[10]) row_open[sd_ba] = 1'b0;
        end
        4'b0010: if (sd_addr[10]) for (int b = 0; b < 4; b++) row_open[b] = 1'b0;
        4'b0001: chk(!(row_open[0] | row_open[1] | row_open[2] | row_open[3]),
                     "R6 refresh with open row", 1, 0);
        default: ;
      endcase
    end
    sd_dq_in <= pv[0] ? pd[0] : 16'hDEAD;
    for (int i = 0; i < 3; i++) begin pv[i] = pv[i+1]; pd[i] = pd[i+1]; end
    pv[3] = 1'b0;
  end

  // scoreboard queues and pin monitor
  logic [15:0] exp_q [$];
  int          rd_q  [$];
  logic [3:0]  init_cmd [4];
  logic [12:0] init_adr [4];
  logic [1:0]  init_ba  [4];
  int          init_n = 0, pre_cyc = -1, rel_cyc = 0;
  int          last_ref = -1, ref_cnt = 0;
  bit          mrs_done = 1'b0;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n && !done) begin
      if (c != 4'b0111 && init_n < 4) begin
        init_cmd[init_n] = c; init_adr[init_n] = sd_addr; init_ba[init_n] = sd_ba;
        if (init_n == 0) pre_cyc = cyc;
        init_n++;
      end
      if (c == 4'b0000) mrs_done = 1'b1;
      if (sd_dq_oe) chk(c == 4'b0100, "R8 oe outside write", c, 4'b0100);
      if (c == 4'b0101) rd_q.push_back(cyc);
      if (c == 4'b0001 && mrs_done) begin
        if (last_ref >= 0)
          chk(cyc - last_ref <= REF_INT + SLACK, "R10 refresh gap", cyc - last_ref, REF_INT + SLACK);
        last_ref = cyc; ref_cnt++;
      end
      if (rsp_valid) begin
        if (rd_q.size() == 0 || exp_q.size() == 0) chk(0, "R9 unexpected response", rsp_data, 0);
        else begin
          int rc;
          logic [15:0] e;
          rc = rd_q.pop_front(); e = exp_q.pop_front();
          chk(cyc - rc == CL + 1, "R9 read latency", cyc - rc, CL + 1);
          chk(rsp_data == e, "R11 read data", rsp_data, e);
        end
      end
    end
  end

  logic [15:0] shadow [int];

  task automatic send(input bit we, input logic [23:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_write(input logic [23:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] o;
    o = shadow.exists(a) ? shadow[a] : 16'h0000;
    shadow[a] = {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
    send(1'b1, a, d, be);
  endtask

  task automatic host_read(input logic [23:0] a);
    exp_q.push_back(shadow.exists(a) ? shadow[a] : 16'h0000);
    send(1'b0, a, 16'h0, 2'b11);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin row_open[b] = 0; act_cyc[b] = 0; pv[b] = 0; pd[b] = 0; end
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(sd_cke == 1'b0, "R1 cke in reset", sd_cke, 0);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      chk(!req_ready, "R1 ready in reset", req_ready, 0);
    end
    rst_n = 1'b1; rel_cyc = cyc;
    repeat (INIT_CYC / 2) @(negedge clk);
    chk(!req_ready, "R1 ready during power-up", req_ready, 0);
    chk(sd_cke, "R1 cke after reset", sd_cke, 1);
    while (!req_ready) @(negedge clk);
    // R2 / R3 / R4 power-up order and key
    chk(pre_cyc - rel_cyc >= INIT_CYC, "R2 NOP wait", pre_cyc - rel_cyc, INIT_CYC);
    chk(init_cmd[0] == 4'b0010 && init_adr[0][10], "R2 R4 precharge all", init_cmd[0], 4'b0010);
    chk(init_cmd[1] == 4'b0001, "R2 R4 first refresh", init_cmd[1], 4'b0001);
    chk(init_cmd[2] == 4'b0001, "R2 R4 second refresh", init_cmd[2], 4'b0001);
    chk(init_cmd[3] == 4'b0000, "R2 R4 mode load", init_cmd[3], 4'b0000);
    chk(init_adr[3] == 13'h0230 && init_ba[3] == 2'b00, "R3 mode key", init_adr[3], 13'h0230);

    // R5 R11 distinct banks, rows and columns
    host_write(24'h000000, 16'h1234, 2'b11);
    host_write(24'hC00000 | 24'h1FF, 16'hBEEF, 2'b11);
    host_write({2'b01, 13'h1ABC, 9'h055}, 16'hA5A5, 2'b11);
    host_write({2'b10, 13'h0001, 9'h100}, 16'h0F0F, 2'b11);
    host_read(24'h000000);
    host_read(24'hC00000 | 24'h1FF);
    host_read({2'b01, 13'h1ABC, 9'h055});
    host_read({2'b10, 13'h0001, 9'h100});
    host_read({2'b11, 13'h1FFF, 9'h000}); // never written
    // R8 byte masks
    host_write(24'h000010, 16'h1122, 2'b11);
    host_write(24'h000010, 16'hAAFF, 2'b01);
    host_read(24'h000010);
    host_write(24'h000010, 16'h77BB, 2'b10);
    host_read(24'h000010);
    host_write(24'h000010, 16'h5555, 2'b00);
    host_read(24'h000010);
    // R7 R10 back-to-back traffic spanning several refresh intervals
    for (int i = 0; i < 40; i++) begin
      host_write({i[1:0], 13'(i * 37), 9'(i * 5)}, 16'(i * 16'h0101 + 3), 2'b11);
      host_read({i[1:0], 13'(i * 37), 9'(i * 5)});
    end
    // R10 idle refresh pacing
    begin
      int r0;
      r0 = ref_cnt;
      repeat (REF_INT * 4) @(negedge clk);
      chk(ref_cnt - r0 >= 3, "R10 idle refresh count", ref_cnt - r0, 3);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all responses returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule